// File: doc/BRIEF.md
# Trigger and Road Data Merger with Crossing Check

This block joins one trigger record with the track-road words that belong to the same beam crossing, and writes them out as a single framed block. A trigger record carries a bunch-crossing number, a turn number and a 16-bit field of trigger information. The road data comes from a first-word-fall-through FIFO. Each event there begins with a tag word that names its own crossing and turn and gives the number of payload words that follow it.

Before any output word is produced, the block compares the crossing and turn numbers of the trigger record with those in the road tag. When both agree, the block emits four things in order: a header word, a trigger-information word, the road payload words unchanged, and a trailer. The trailer holds the number of road words that were actually passed through.

When either number disagrees, nothing of that event is emitted. The block pulses an error message toward the trigger hub and then freezes. It stays frozen until the clear input is pulsed, and a sticky error status shows the frozen state.

All three streams use valid/ready handshakes:
- **Trigger input:** a record is taken on a cycle where valid and ready are both high.
- **Road input:** a road word is popped on a cycle where `road_valid` and `road_ready` are both high. `road_valid` means the FIFO is not empty, and `road_ready` is the pop strobe.
- **Output:** a word transfers when `out_valid` and `out_ready` are both high, and `out_ready` is the inverted full flag of the downstream FIFO. While `out_valid` is high and `out_ready` is low, the word on offer stays as it is. Back-pressure on the output also stops road words from being popped, so no word is lost.

Top module: `trk_merge`

## Requirements
- R1: After reset, `out_valid`, `err_msg` and `err_sticky` are 0 and `trig_ready` is 1.
- R2: A trigger record is accepted when `trig_valid` and `trig_ready` are both 1. `trig_ready` then stays 0 until that event's trailer is accepted, or until a clear ends a halt.
- R3: The road tag word holds three fields: payload count in bits [31:24], crossing number in [23:16] and turn number in [15:0]. When the crossing and turn both equal the latched trigger values, the block emits the event block.
- R4: The block's words appear in this order. First the header `{8'hE1, bx, turn}`. Then the trigger word `{16'h5A00, info}`. Then each road payload word, unchanged. Last the trailer `{8'hE2, bx, 8'h00, count}`.
- R5: The trailer's count is the number of road payload words emitted. A tag count of 0 gives a three-word block: header, trigger word and trailer.
- R6: On a crossing or turn mismatch, the tag word is popped and no word of that event is emitted. `err_msg` is high for exactly one cycle, in the cycle after the tag pop.
- R7: After a mismatch the block is halted. `err_sticky` is 1 and `trig_ready`, `road_ready` and `out_valid` are all 0, whatever the inputs do, until `clr` is pulsed. The clear returns the block to idle with `err_sticky` at 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value and `out_valid` stays 1. Stalls lose no words and duplicate none.
- R9: `road_ready` is never 1 while `road_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger record present |
| trig_ready | output | 1 | Trigger record can be taken |
| trig_bx | input | 8 | Trigger bunch-crossing number |
| trig_turn | input | 16 | Trigger turn number |
| trig_info | input | 16 | Trigger information field |
| road_valid | input | 1 | Road FIFO not empty |
| road_ready | output | 1 | Road FIFO pop |
| road_data | input | 32 | Road FIFO head word |
| out_valid | output | 1 | Formatted word present |
| out_ready | input | 1 | Output FIFO not full |
| out_data | output | 32 | Formatted word |
| err_msg | output | 1 | One-cycle error message to the trigger hub |
| err_sticky | output | 1 | Halted after a mismatch |
| clr | input | 1 | Clears a halt |

## Verification
The merge is tried with matching events of several payload lengths, including zero words and the all-ones crossing and turn values, to show that framing and counting do not depend on the event size. Some of these events run with a free output and some with a stalling output, which separates correct holding of words from loss or duplication. Mismatches in the crossing number alone and in the turn number alone each show that either comparison on its own blocks emission. A halt in which a trigger record and a road word are both offered shows that the frozen block takes nothing until the clear.

// File: rtl/trkm_pkg.sv
package trkm_pkg;
  localparam int BX_W   = 8;
  localparam int TURN_W = 16;
  localparam int INFO_W = 16;
  localparam int CODE_W = 8;
  localparam int WORD_W = CODE_W + BX_W + TURN_W;
  localparam int CNT_W  = WORD_W - BX_W - TURN_W;
  localparam int MARK_W = WORD_W - INFO_W;
  localparam int PAD_W  = TURN_W - CNT_W;

  localparam logic [CODE_W-1:0] HDR_CODE  = 8'hE1;
  localparam logic [CODE_W-1:0] TRL_CODE  = 8'hE2;
  localparam logic [MARK_W-1:0] INFO_MARK = MARK_W'('h5A00);

  typedef enum logic [2:0] {
    S_IDLE, S_TAG, S_HDR, S_INFO, S_ROAD, S_TRL, S_HALT
  } mstate_t;
endpackage

// File: rtl/trkm_cmp.sv
module trkm_cmp
  import trkm_pkg::*;
(
  input  logic [BX_W-1:0]   ref_bx,
  input  logic [TURN_W-1:0] ref_turn,
  input  logic [WORD_W-1:0] tag_word,
  output logic              match,
  output logic [CNT_W-1:0]  tag_cnt
);
  logic [BX_W-1:0]   tag_bx;
  logic [TURN_W-1:0] tag_turn;

  assign tag_turn = tag_word[TURN_W-1:0];
  assign tag_bx   = tag_word[TURN_W +: BX_W];
  assign tag_cnt  = tag_word[TURN_W+BX_W +: CNT_W];
  assign match    = (tag_bx == ref_bx) && (tag_turn == ref_turn);
endmodule

// File: rtl/trkm_ctrl.sv
module trkm_ctrl
  import trkm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [BX_W-1:0]   trig_bx,
  input  logic [TURN_W-1:0] trig_turn,
  input  logic [INFO_W-1:0] trig_info,
  input  logic              road_valid,
  input  logic              out_ready,
  input  logic              clr,
  input  logic              match,
  input  logic [CNT_W-1:0]  tag_cnt,
  output mstate_t           st,
  output logic [BX_W-1:0]   lat_bx,
  output logic [TURN_W-1:0] lat_turn,
  output logic [INFO_W-1:0] lat_info,
  output logic [CNT_W-1:0]  cnt,
  output logic              trig_ready,
  output logic              road_ready,
  output logic              out_valid,
  output logic              err_msg
);
  logic [CNT_W-1:0] nwords;
  logic             fire;

  assign trig_ready = (st == S_IDLE);
  assign out_valid  = (st == S_HDR) || (st == S_INFO) || (st == S_TRL) ||
                      (st == S_ROAD && road_valid);
  assign road_ready = road_valid &&
                      ((st == S_TAG) || (st == S_ROAD && out_ready));
  assign fire       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      lat_bx   <= '0;
      lat_turn <= '0;
      lat_info <= '0;
      cnt      <= '0;
      nwords   <= '0;
      err_msg  <= 1'b0;
    end else begin
      err_msg <= 1'b0;
      unique case (st)
        S_IDLE: if (trig_valid) begin
          lat_bx   <= trig_bx;
          lat_turn <= trig_turn;
          lat_info <= trig_info;
          st       <= S_TAG;
        end
        S_TAG: if (road_valid) begin
          if (match) begin
            nwords <= tag_cnt;
            cnt    <= '0;
            st     <= S_HDR;
          end else begin
            err_msg <= 1'b1;
            st      <= S_HALT;
          end
        end
        S_HDR:  if (fire) st <= S_INFO;
        S_INFO: if (fire) st <= (nwords == '0) ? S_TRL : S_ROAD;
        S_ROAD: if (fire) begin
          cnt <= cnt + CNT_W'(1);
          if ((cnt + CNT_W'(1)) == nwords) st <= S_TRL;
        end
        S_TRL:  if (fire) st <= S_IDLE;
        S_HALT: if (clr) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: payload counter never runs past the tag count
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ROAD) |-> (cnt < nwords));
  // R6: error message lasts one cycle
  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_msg |=> !err_msg);
  // R2: a taken record closes the trigger port
  assert_trig_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_ready) |=> !trig_ready);
endmodule

// File: rtl/trkm_fmt.sv
module trkm_fmt
  import trkm_pkg::*;
(
  input  mstate_t           st,
  input  logic [BX_W-1:0]   lat_bx,
  input  logic [TURN_W-1:0] lat_turn,
  input  logic [INFO_W-1:0] lat_info,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [WORD_W-1:0] road_data,
  output logic [WORD_W-1:0] out_data
);
  always_comb begin
    case (st)
      S_HDR:   out_data = {HDR_CODE, lat_bx, lat_turn};
      S_INFO:  out_data = {INFO_MARK, lat_info};
      S_ROAD:  out_data = road_data;
      S_TRL:   out_data = {TRL_CODE, lat_bx, {PAD_W{1'b0}}, cnt};
      default: out_data = '0;
    endcase
  end
endmodule

// File: rtl/trk_merge.sv
module trk_merge
  import trkm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [BX_W-1:0]   trig_bx,
  input  logic [TURN_W-1:0] trig_turn,
  input  logic [INFO_W-1:0] trig_info,
  input  logic              road_valid,
  output logic              road_ready,
  input  logic [WORD_W-1:0] road_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              err_msg,
  output logic              err_sticky,
  input  logic              clr
);
  mstate_t           st;
  logic [BX_W-1:0]   lat_bx;
  logic [TURN_W-1:0] lat_turn;
  logic [INFO_W-1:0] lat_info;
  logic [CNT_W-1:0]  cnt, tag_cnt;
  logic              match;

  trkm_cmp u_cmp (
    .ref_bx(lat_bx), .ref_turn(lat_turn), .tag_word(road_data),
    .match(match), .tag_cnt(tag_cnt)
  );

  trkm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_bx(trig_bx),
    .trig_turn(trig_turn), .trig_info(trig_info), .road_valid(road_valid),
    .out_ready(out_ready), .clr(clr), .match(match), .tag_cnt(tag_cnt),
    .st(st), .lat_bx(lat_bx), .lat_turn(lat_turn), .lat_info(lat_info),
    .cnt(cnt), .trig_ready(trig_ready), .road_ready(road_ready),
    .out_valid(out_valid), .err_msg(err_msg)
  );

  trkm_fmt u_fmt (
    .st(st), .lat_bx(lat_bx), .lat_turn(lat_turn), .lat_info(lat_info),
    .cnt(cnt), .road_data(road_data), .out_data(out_data)
  );

  assign err_sticky = (st == S_HALT);

  // R8: a stalled word is held
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R7: a halted block is quiet on every port
  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |-> (!out_valid && !trig_ready && !road_ready));
  // R6: the error message comes with the halt
  assert_err_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_msg |-> err_sticky);
  // R9: no pop from an empty FIFO
  assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    road_ready |-> road_valid);
endmodule

// File: tb/sim_trk_merge.sv
module sim_trk_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_valid = 1'b0, trig_ready;
  logic [7:0]  trig_bx = '0;
  logic [15:0] trig_turn = '0, trig_info = '0;
  logic        road_valid, road_ready;
  logic [31:0] road_data;
  logic        out_valid, out_ready;
  logic [31:0] out_data;
  logic        err_msg, err_sticky;
  logic        clr = 1'b0;

  always #4 clk = ~clk;

  trk_merge u0 (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_bx(trig_bx), .trig_turn(trig_turn), .trig_info(trig_info),
    .road_valid(road_valid), .road_ready(road_ready), .road_data(road_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .err_msg(err_msg), .err_sticky(err_sticky), .clr(clr)
  );

  // bench road FIFO (first word falls through)
  logic [31:0] rd_mem [64];
  logic [5:0]  wr_ptr = '0;
  logic [5:0]  rd_ptr = '0;
  assign road_valid = (rd_ptr != wr_ptr);
  assign road_data  = rd_mem[rd_ptr];

  // output sink and monitors
  logic [31:0] cap [256];
  int cap_n = 0, err_n = 0, hold_bad = 0, bad_pop = 0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_data = '0;
  logic        stall_en = 1'b0, hold_all = 1'b0;
  int          cyc = 0;
  assign out_ready = !hold_all && !(stall_en && (cyc % 3 != 0));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (road_ready && road_valid) rd_ptr <= rd_ptr + 6'd1;
      if (road_ready && !road_valid) bad_pop <= bad_pop + 1;
      if (out_valid && out_ready) begin
        cap[cap_n[7:0]] <= out_data;
        cap_n <= cap_n + 1;
      end
      if (err_msg) err_n <= err_n + 1;
      if (prev_stall && (!out_valid || out_data != prev_data))
        hold_bad <= hold_bad + 1;
      prev_stall <= out_valid && !out_ready;
      prev_data  <= out_data;
    end
  end

  int total = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    rd_mem[wr_ptr] = w;
    wr_ptr = wr_ptr + 6'd1;
  endtask

  task automatic send_trig(input logic [7:0] bx, input logic [15:0] turn,
                           input logic [15:0] info);
    @(negedge clk);
    trig_bx = bx; trig_turn = turn; trig_info = info; trig_valid = 1'b1;
    while (!trig_ready) @(negedge clk);
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [7:0]  bx_t;
    logic [15:0] turn_t;
    logic [7:0]  bx_r;
    logic [15:0] turn_r;
    logic [7:0]  n;
    logic [15:0] info;
    logic        stall;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h0C, 16'h0100, 8'h0C, 16'h0100, 8'd3, 16'hBEEF, 1'b0},
    '{8'hFF, 16'hFFFF, 8'hFF, 16'hFFFF, 8'd0, 16'h1234, 1'b0},
    '{8'h40, 16'h2222, 8'h40, 16'h2222, 8'd5, 16'h0A0A, 1'b1},
    '{8'h41, 16'h3333, 8'h42, 16'h3333, 8'd0, 16'h0000, 1'b0},
    '{8'h50, 16'h4444, 8'h50, 16'h4445, 8'd0, 16'h0000, 1'b0},
    '{8'h00, 16'h0000, 8'h00, 16'h0000, 8'd2, 16'hFFFF, 1'b1}
  };

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: run did not end");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    int base, ebase, wt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 err_msg", {31'd0, err_msg}, 32'd0);
    chk("R1 err_sticky", {31'd0, err_sticky}, 32'd0);
    chk("R1 trig_ready", {31'd0, trig_ready}, 32'd1);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      base = cap_n; ebase = err_n;
      stall_en = VECS[v].stall;
      push({VECS[v].n, VECS[v].bx_r, VECS[v].turn_r});
      for (int k = 0; k < VECS[v].n; k++) push(32'hD000_0000 | (v << 8) | k);
      send_trig(VECS[v].bx_t, VECS[v].turn_t, VECS[v].info);
      if (VECS[v].bx_t == VECS[v].bx_r && VECS[v].turn_t == VECS[v].turn_r) begin
        wt = 0;
        while (cap_n < base + VECS[v].n + 3 && wt < 200) begin @(negedge clk); wt++; end
        @(negedge clk);
        chk("R3 block length", cap_n - base, VECS[v].n + 3);
        chk("R4 header", cap[base[7:0]], {8'hE1, VECS[v].bx_t, VECS[v].turn_t});
        chk("R4 trigger word", cap[(base + 1) & 255], {16'h5A00, VECS[v].info});
        for (int k = 0; k < VECS[v].n; k++)
          chk("R4 road word", cap[(base + 2 + k) & 255], 32'hD000_0000 | (v << 8) | k);
        chk("R5 trailer count", cap[(base + 2 + VECS[v].n) & 255],
            {8'hE2, VECS[v].bx_t, 8'h00, VECS[v].n});
        chk("R2 ready after trailer", {31'd0, trig_ready}, 32'd1);
      end else begin
        repeat (6) @(negedge clk);
        chk("R6 one error pulse", err_n - ebase, 32'd1);
        chk("R6 nothing emitted", cap_n - base, 32'd0);
        chk("R7 sticky set", {31'd0, err_sticky}, 32'd1);
        chk("R7 trig blocked", {31'd0, trig_ready}, 32'd0);
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        chk("R7 sticky cleared", {31'd0, err_sticky}, 32'd0);
        chk("R7 idle after clear", {31'd0, trig_ready}, 32'd1);
      end
    end
    stall_en = 1'b0;

    // R7: halted block ignores a trigger record and a road word
    base = cap_n;
    push({8'd0, 8'h77, 16'h7777});
    send_trig(8'h78, 16'h7777, 16'h0);
    repeat (3) @(negedge clk);
    push({8'd0, 8'h90, 16'h9090});
    trig_valid = 1'b1; trig_bx = 8'h90; trig_turn = 16'h9090; trig_info = 16'hCAFE;
    repeat (5) @(negedge clk);
    chk("R7 road word not popped", {26'd0, wr_ptr - rd_ptr}, 32'd1);
    chk("R7 no output in halt", cap_n - base, 32'd0);
    chk("R7 trig held off", {31'd0, trig_ready}, 32'd0);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    while (!trig_ready) @(negedge clk);
    @(negedge clk); trig_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk("R7 event after clear", cap_n - base, 32'd3);
    chk("R5 zero-length trailer", cap[(base + 2) & 255], {8'hE2, 8'h90, 8'h00, 8'h00});

    // R2/R8: output held off, trigger port stays closed
    hold_all = 1'b1; base = cap_n;
    push({8'd1, 8'h21, 16'h2121});
    push(32'h1111_2222);
    send_trig(8'h21, 16'h2121, 16'h0055);
    repeat (4) @(negedge clk);
    chk("R2 trig closed during event", {31'd0, trig_ready}, 32'd0);
    chk("R8 header offered under stall", out_data, {8'hE1, 8'h21, 16'h2121});
    chk("R8 nothing taken under stall", cap_n - base, 32'd0);
    hold_all = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 full block after stall", cap_n - base, 32'd4);
    chk("R4 road word after stall", cap[(base + 2) & 255], 32'h1111_2222);
    chk("R8 stalled words held", hold_bad, 32'd0);
    chk("R9 no empty pops", bad_pop, 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule